// File: doc/BRIEF.md
# Processor Sleep-State Sequencer

This block lives on the chipset side of a processor power-management path. It takes a processor from normal execution into a deep low-power state, or into a system-level S1 sleep, and later brings it back. On an entry request it lowers the active-low stop-clock line and waits for the processor's stop-grant indication. It then lowers the active-low sleep line and finally withdraws the host clock enable. On a wake request it walks the same steps backwards. In S1 mode it also withdraws the PCI clock enable for exactly as long as sleep is asserted.

Every minimum spacing between these edges is a parameter counted in cycles of the free-running reference clock. Each value is rounded up from the analog requirement for the chosen reference frequency. A single reload counter times every step. The wait for stop-grant has an upper bound. If the grant does not come in time, the block raises a sticky timeout flag and abandons the entry. A wake that arrives while entry is still in progress is remembered. It takes effect only once the sleeping state has been reached, so no interval is ever cut short.

Top module: `slp_seq`

## Requirements
- R1: While reset is held low at a clock edge, the outputs take these values: stpclk_n_o=1, sleep_n_o=1, hclk_en_o=1, pci_en_o=1, busy_o=0, asleep_o=0, tmo_err_o=0.
- R2: An entry request sampled while idle lowers stpclk_n_o and raises busy_o at that edge, and samples mode_s1_i (1 = S1, 0 = deep sleep). The stop-grant input is accepted at any of the ACK_WIN_CYC edges that follow.
- R3: sleep_n_o falls exactly GNT_SLP_CYC edges after the edge that accepted stop-grant.
- R4: hclk_en_o falls and asleep_o rises exactly SLP_HOFF_CYC edges after sleep_n_o falls. The host clock is off only while both sleep and stop-clock are asserted.
- R5: In deep-sleep mode the host clock restarts (hclk_en_o rises, asleep_o falls) at the first edge that samples a wake while asleep, one edge after entering the asleep state at the earliest.
- R6: sleep_n_o rises exactly HON_SLPREL_CYC edges after hclk_en_o rises.
- R7: stpclk_n_o rises exactly SLPREL_STPREL_CYC edges after sleep_n_o rises.
- R8: busy_o falls exactly STPREL_RUN_CYC edges after stpclk_n_o rises, after which a new entry request is accepted.
- R9: In S1 mode pci_en_o falls and rises at the same edges as sleep_n_o. In deep-sleep mode pci_en_o stays 1 throughout.
- R10: In S1 mode the host clock stays off for at least S1_HOLD_CYC edges. A wake that arrives sooner is held until then.
- R11: If no stop-grant is sampled within the window, stpclk_n_o rises, busy_o falls and tmo_err_o rises ACK_WIN_CYC edges after stpclk_n_o fell. A stop-grant that arrives later has no effect. tmo_err_o stays 1 until the next accepted entry request clears it.
- R12: A wake sampled during entry is held until the asleep state's dwell is met. A wake sampled while idle, or during exit, has no effect on any later sleep.
- R13: Entry requests and mode changes that arrive while busy_o is 1 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req_i | input | 1 | Request to enter the low-power state |
| mode_s1_i | input | 1 | 1 selects S1 (PCI clock also gated), 0 selects deep sleep |
| wake_i | input | 1 | Request to leave the low-power state |
| stpgnt_i | input | 1 | Stop-grant acknowledge from the processor |
| stpclk_n_o | output | 1 | Active-low stop-clock request |
| sleep_n_o | output | 1 | Active-low sleep request |
| hclk_en_o | output | 1 | Host clock enable |
| pci_en_o | output | 1 | PCI clock enable |
| busy_o | output | 1 | Sequencer is away from the running state |
| asleep_o | output | 1 | Host clock is stopped |
| tmo_err_o | output | 1 | Sticky stop-grant timeout flag |

## Verification
The bench aims at the edges of the grant window. A grant on the last permitted edge must be accepted, and one edge later it must trigger the abort. An off-by-one counter would abort the good case or sleep on the bad one. S1 wakes that arrive before, during and well after the PCI hold dwell are exercised. A design that does not hold an early wake would either restart the host clock too soon or hang. Wakes issued while idle and during exit, and entry requests with a flipped mode issued mid-sleep, must leave the next sequence untouched. A leaking wake latch or a mode that is sampled live would show up as a short dwell or a spurious PCI clock edge.

// File: rtl/slp_pkg.sv
// Shared types for the sleep-state sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package slp_pkg;

    // Sequencer states, listed in the order the sequence walks them
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_STPC   = 3'd1,   // stop-clock low, waiting for grant
        ST_GNT    = 3'd2,   // grant seen, spacing before sleep
        ST_SLPW   = 3'd3,   // sleep low, spacing before host clock off
        ST_ASLEEP = 3'd4,   // host clock off
        ST_HRUN   = 3'd5,   // host clock back, sleep still low
        ST_SLPREL = 3'd6,   // sleep released, stop-clock still low
        ST_STPREL = 3'd7    // stop-clock released, settling to run
    } slp_state_e;

    // Larger of two counts, for deriving counter widths
    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slp_dwell_timer.sv
// Reload down-counter that times each sequencer step.
// Assumes: load_i takes precedence; done_o is high while the count is zero.
module slp_dwell_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_q;

    // Reload on step change, otherwise count down to zero and stay there
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/slp_fsm.sv
// Step controller: decides the next state, the timer reload value,
// the latched mode, the held wake and the sticky timeout flag.
// Assumes: every *_CYC parameter is at least 1; inputs are synchronous to clk.
module slp_fsm
    import slp_pkg::*;
#(
    parameter int unsigned ACK_WIN_CYC       = 16,
    parameter int unsigned GNT_SLP_CYC       = 4,
    parameter int unsigned SLP_HOFF_CYC      = 2,
    parameter int unsigned S1_HOLD_CYC       = 6,
    parameter int unsigned HON_SLPREL_CYC    = 10,
    parameter int unsigned SLPREL_STPREL_CYC = 3,
    parameter int unsigned STPREL_RUN_CYC    = 5,
    parameter int unsigned CW                = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req_i,
    input  logic          mode_s1_i,
    input  logic          wake_i,
    input  logic          stpgnt_i,
    input  logic          tmr_done_i,
    output slp_state_e    state_o,
    output slp_state_e    nxt_o,
    output logic          mode_q_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          tmo_err_o
);

    localparam logic [CW-1:0] V_ACK  = CW'(ACK_WIN_CYC - 1);
    localparam logic [CW-1:0] V_GNT  = CW'(GNT_SLP_CYC - 1);
    localparam logic [CW-1:0] V_HOFF = CW'(SLP_HOFF_CYC - 1);
    localparam logic [CW-1:0] V_HOLD = CW'(S1_HOLD_CYC - 1);
    localparam logic [CW-1:0] V_HON  = CW'(HON_SLPREL_CYC - 1);
    localparam logic [CW-1:0] V_SREL = CW'(SLPREL_STPREL_CYC - 1);
    localparam logic [CW-1:0] V_PREL = CW'(STPREL_RUN_CYC - 1);

    slp_state_e state_q, nxt;
    logic       wake_pend_q, mode_q, tmo_q;
    logic       timeout, entry_st, wake_any;

    assign entry_st = (state_q == ST_STPC) || (state_q == ST_GNT) ||
                      (state_q == ST_SLPW) || (state_q == ST_ASLEEP);
    assign wake_any = wake_pend_q | wake_i;

    // Next-state choice: each step leaves only when its dwell has run out
    always_comb begin
        nxt     = state_q;
        timeout = 1'b0;
        case (state_q)
            ST_RUN:    if (sleep_req_i) nxt = ST_STPC;
            ST_STPC: begin
                if (stpgnt_i)        nxt = ST_GNT;
                else if (tmr_done_i) begin
                    nxt     = ST_RUN;
                    timeout = 1'b1;
                end
            end
            ST_GNT:    if (tmr_done_i) nxt = ST_SLPW;
            ST_SLPW:   if (tmr_done_i) nxt = ST_ASLEEP;
            ST_ASLEEP: if (tmr_done_i && wake_any) nxt = ST_HRUN;
            ST_HRUN:   if (tmr_done_i) nxt = ST_SLPREL;
            ST_SLPREL: if (tmr_done_i) nxt = ST_STPREL;
            ST_STPREL: if (tmr_done_i) nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    // Dwell to load for the step being entered
    always_comb begin
        case (nxt)
            ST_STPC:   tmr_val_o = V_ACK;
            ST_GNT:    tmr_val_o = V_GNT;
            ST_SLPW:   tmr_val_o = V_HOFF;
            ST_ASLEEP: tmr_val_o = mode_q ? V_HOLD : '0;
            ST_HRUN:   tmr_val_o = V_HON;
            ST_SLPREL: tmr_val_o = V_SREL;
            ST_STPREL: tmr_val_o = V_PREL;
            default:   tmr_val_o = '0;
        endcase
    end
    assign tmr_load_o = (nxt != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= nxt;
    end

    // Mode is sampled only when an entry request is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                                   mode_q <= 1'b0;
        else if (state_q == ST_RUN && sleep_req_i)    mode_q <= mode_s1_i;
    end

    // Wake seen during entry or sleep is held until the asleep step ends
    always_ff @(posedge clk) begin
        if (!rst_n)                                       wake_pend_q <= 1'b0;
        else if (state_q == ST_ASLEEP && nxt != ST_ASLEEP) wake_pend_q <= 1'b0;
        else if (entry_st && nxt != ST_RUN)               wake_pend_q <= wake_pend_q | wake_i;
        else                                              wake_pend_q <= 1'b0;
    end

    // Timeout flag: set on abort, cleared by the next accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                                   tmo_q <= 1'b0;
        else if (timeout)                             tmo_q <= 1'b1;
        else if (state_q == ST_RUN && sleep_req_i)    tmo_q <= 1'b0;
    end

    assign state_o   = state_q;
    assign nxt_o     = nxt;
    assign mode_q_o  = mode_q;
    assign tmo_err_o = tmo_q;

    // R12: a wake held past the asleep step would shorten a later sleep
    a_r12_pend_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !wake_pend_q);

endmodule

// File: rtl/slp_pin_reg.sv
// Output stage: registers the pin levels for the state being entered,
// so every pin changes on the same edge as the state register.
// Assumes: mode_q_i is already latched whenever the next state gates sleep.
module slp_pin_reg
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_e nxt_i,
    input  logic       mode_q_i,
    output logic       stpclk_n_o,
    output logic       sleep_n_o,
    output logic       hclk_en_o,
    output logic       pci_en_o,
    output logic       busy_o,
    output logic       asleep_o
);

    logic stp_on, slp_on;

    assign slp_on = (nxt_i == ST_SLPW) || (nxt_i == ST_ASLEEP) || (nxt_i == ST_HRUN);
    assign stp_on = slp_on || (nxt_i == ST_STPC) || (nxt_i == ST_GNT) || (nxt_i == ST_SLPREL);

    // Glitch-free registered pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stpclk_n_o <= 1'b1;
            sleep_n_o  <= 1'b1;
            hclk_en_o  <= 1'b1;
            pci_en_o   <= 1'b1;
            busy_o     <= 1'b0;
            asleep_o   <= 1'b0;
        end else begin
            stpclk_n_o <= !stp_on;
            sleep_n_o  <= !slp_on;
            hclk_en_o  <= (nxt_i != ST_ASLEEP);
            pci_en_o   <= !(slp_on && mode_q_i);
            busy_o     <= (nxt_i != ST_RUN);
            asleep_o   <= (nxt_i == ST_ASLEEP);
        end
    end

endmodule

// File: rtl/slp_seq.sv
// Top of the sleep-state sequencer: step controller, shared dwell timer
// and registered output stage.
// Assumes: all *_CYC values are already rounded up to reference-clock cycles.
module slp_seq
    import slp_pkg::*;
#(
    parameter int unsigned ACK_WIN_CYC       = 16,
    parameter int unsigned GNT_SLP_CYC       = 4,
    parameter int unsigned SLP_HOFF_CYC      = 2,
    parameter int unsigned S1_HOLD_CYC       = 6,
    parameter int unsigned HON_SLPREL_CYC    = 10,
    parameter int unsigned SLPREL_STPREL_CYC = 3,
    parameter int unsigned STPREL_RUN_CYC    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic mode_s1_i,
    input  logic wake_i,
    input  logic stpgnt_i,
    output logic stpclk_n_o,
    output logic sleep_n_o,
    output logic hclk_en_o,
    output logic pci_en_o,
    output logic busy_o,
    output logic asleep_o,
    output logic tmo_err_o
);

    localparam int unsigned MAXC = imax(imax(imax(ACK_WIN_CYC, GNT_SLP_CYC),
                                             imax(SLP_HOFF_CYC, S1_HOLD_CYC)),
                                        imax(imax(HON_SLPREL_CYC, SLPREL_STPREL_CYC),
                                             STPREL_RUN_CYC));
    localparam int unsigned CW = $clog2(MAXC + 1);

    slp_state_e    state, nxt;
    logic          mode_q, tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;

    slp_fsm #(
        .ACK_WIN_CYC(ACK_WIN_CYC), .GNT_SLP_CYC(GNT_SLP_CYC),
        .SLP_HOFF_CYC(SLP_HOFF_CYC), .S1_HOLD_CYC(S1_HOLD_CYC),
        .HON_SLPREL_CYC(HON_SLPREL_CYC), .SLPREL_STPREL_CYC(SLPREL_STPREL_CYC),
        .STPREL_RUN_CYC(STPREL_RUN_CYC), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req_i), .mode_s1_i(mode_s1_i),
        .wake_i(wake_i), .stpgnt_i(stpgnt_i), .tmr_done_i(tmr_done),
        .state_o(state), .nxt_o(nxt), .mode_q_o(mode_q), .tmr_load_o(tmr_load),
        .tmr_val_o(tmr_val), .tmo_err_o(tmo_err_o)
    );

    slp_dwell_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
    );

    slp_pin_reg u_pins (
        .clk(clk), .rst_n(rst_n), .nxt_i(nxt), .mode_q_i(mode_q),
        .stpclk_n_o(stpclk_n_o), .sleep_n_o(sleep_n_o), .hclk_en_o(hclk_en_o),
        .pci_en_o(pci_en_o), .busy_o(busy_o), .asleep_o(asleep_o)
    );

    // R9: PCI clock is only withheld while sleep is asserted
    a_r9_pci_inside_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_en_o |-> !sleep_n_o);
    // R9: PCI clock is running again whenever sleep is released
    a_r9_pci_back_with_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_n_o) |-> pci_en_o);
    // R4: host clock off only inside sleep and stop-clock
    a_r4_hoff_nested: assert property (@(posedge clk) disable iff (!rst_n)
        !hclk_en_o |-> (!sleep_n_o && !stpclk_n_o));
    // R3: sleep falls only when the grant spacing has expired
    a_r3_sleep_fall_timed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_n_o) |-> $past(tmr_done));
    // R6: sleep rises only when the post-restart spacing has expired
    a_r6_sleep_rise_timed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_n_o) |-> $past(tmr_done));
    // R7: stop-clock rises only when a dwell (spacing or grant window) has run out
    a_r7_stp_rise_timed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stpclk_n_o) |-> $past(tmr_done));
    // R13: latched mode never changes during a sequence
    a_r13_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_q));
    // R11: abort leaves the pins in the running configuration
    a_r11_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err_o) |-> (stpclk_n_o && !busy_o));

endmodule

// File: tb/sim_slp_seq.sv
// Scoreboard bench: the driver queues expected output changes with their
// spacing in cycles; the monitor pops one per observed change.
module sim_slp_seq;

    localparam int CLK_P   = 10;
    localparam int ACK_W   = 16;
    localparam int GNT_S   = 4;
    localparam int HOFF_S  = 2;
    localparam int HOLD_S  = 6;
    localparam int HON_S   = 10;
    localparam int SREL_S  = 3;
    localparam int PREL_S  = 5;

    // vector order: {busy, asleep, stpclk_n, sleep_n, hclk_en, pci_en}
    localparam logic [5:0] V_IDLE = 6'b001111;
    localparam logic [5:0] V_STPC = 6'b100111;

    typedef struct {
        logic [5:0] v;
        int         gap;   // -1: spacing not checked
        string      tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, mode_s1 = 1'b0, wake = 1'b0, stpgnt = 1'b0;
    logic stpclk_n, sleep_n, hclk_en, pci_en, busy, asleep, tmo_err;

    int n_cmp = 0, n_bad = 0, gap = 0;
    logic [5:0] last_v = V_IDLE;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    slp_seq u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .mode_s1_i(mode_s1),
        .wake_i(wake), .stpgnt_i(stpgnt), .stpclk_n_o(stpclk_n), .sleep_n_o(sleep_n),
        .hclk_en_o(hclk_en), .pci_en_o(pci_en), .busy_o(busy), .asleep_o(asleep),
        .tmo_err_o(tmo_err)
    );

    function automatic logic [5:0] cur_vec();
        return {busy, asleep, stpclk_n, sleep_n, hclk_en, pci_en};
    endfunction

    task automatic chk(input bit ok, input string tg, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tg, act, exp_v);
        end
    endtask

    task automatic push(input logic [5:0] v, input int g, input string tg);
        exp_t e;
        e.v = v; e.gap = g; e.tag = tg;
        q.push_back(e);
    endtask

    // Monitor: one comparison per observed change of the output vector
    always @(negedge clk) begin
        if (rst_n) begin
            logic [5:0] v;
            exp_t e;
            gap++;
            v = cur_vec();
            if (v !== last_v) begin
                n_cmp++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R13 unexpected change: actual %b expected %b", v, last_v);
                end else begin
                    e = q.pop_front();
                    if (v !== e.v || (e.gap >= 0 && gap != e.gap)) begin
                        n_bad++;
                        $display("FAIL %s: actual %b gap %0d expected %b gap %0d",
                                 e.tag, v, gap, e.v, e.gap);
                    end
                end
                last_v = v;
                gap = 0;
            end
        end
    end

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // One sequence. a<0 or a>=ACK_W: grant late or missing (abort).
    task automatic seq(input bit s1, input int a, input bit early, input int late_x,
                       input bit pokes, input bit exit_wake, input string tg);
        logic [5:0] pcib;
        int dw, hgap;
        bit abort;
        abort = (a < 0) || (a >= ACK_W);
        pcib  = s1 ? 6'b000000 : 6'b000001;
        dw    = s1 ? HOLD_S : 1;
        hgap  = early ? dw : ((late_x + 1 > dw) ? late_x + 1 : dw);
        push(V_STPC, -1, {tg, " R2 entry"});
        if (abort) begin
            push(V_IDLE, ACK_W, {tg, " R11 abort"});
        end else begin
            push(6'b100010 | pcib, 1 + a + GNT_S, {tg, " R3/R9 sleep fall"});
            push(6'b110000 | pcib, HOFF_S, {tg, " R4 host off"});
            push(6'b100010 | pcib, hgap, {tg, " R5/R10/R12 host on"});
            push(6'b100111, HON_S, {tg, " R6/R9 sleep rise"});
            push(6'b101111, SREL_S, {tg, " R7 stop-clock rise"});
            push(V_IDLE, PREL_S, {tg, " R8 run"});
        end
        @(negedge clk); sleep_req = 1'b1; mode_s1 = s1;
        @(negedge clk); sleep_req = 1'b0;
        if (early) wake = 1'b1;
        if (a >= 0) begin
            repeat (a) @(negedge clk);
            stpgnt = 1'b1;
            @(negedge clk); stpgnt = 1'b0; wake = 1'b0;
        end
        if (!abort && !early) begin
            do @(negedge clk); while (!asleep);
            if (pokes && late_x >= 3) begin
                @(negedge clk); sleep_req = 1'b1; mode_s1 = !s1;
                @(negedge clk); sleep_req = 1'b0;
                repeat (late_x - 3) @(negedge clk);
                chk(asleep == 1'b1, {tg, " R12 still asleep"}, asleep, 1);
                @(negedge clk);
            end else begin
                repeat (late_x) @(negedge clk);
            end
            wake = 1'b1;
            @(negedge clk); wake = 1'b0;
        end
        if (!abort && exit_wake) begin
            while (asleep) @(negedge clk);
            @(negedge clk); wake = 1'b1;
            @(negedge clk); wake = 1'b0;
        end
        wait_idle();
        mode_s1 = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cur_vec() == V_IDLE, "R1 reset pins", cur_vec(), V_IDLE);
        chk(tmo_err == 1'b0, "R1 reset tmo", tmo_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        seq(1'b0, 3,  1'b1, 0, 1'b0, 1'b0, "deep early-wake");
        seq(1'b0, 15, 1'b0, 0, 1'b0, 1'b0, "deep last-slot grant");
        seq(1'b1, 0,  1'b1, 0, 1'b0, 1'b0, "S1 early-wake");
        seq(1'b1, 5,  1'b0, 2, 1'b0, 1'b0, "S1 wake inside hold");
        seq(1'b1, 1,  1'b0, 9, 1'b0, 1'b0, "S1 wake after hold");

        seq(1'b0, -1, 1'b0, 0, 1'b0, 1'b0, "no grant");
        chk(tmo_err == 1'b1, "R11 flag set", tmo_err, 1);
        seq(1'b0, 16, 1'b0, 0, 1'b0, 1'b0, "grant one late");
        chk(tmo_err == 1'b1, "R11 flag sticky", tmo_err, 1);
        seq(1'b0, 2,  1'b0, 4, 1'b0, 1'b1, "deep after abort, exit wake");
        chk(tmo_err == 1'b0, "R11 flag cleared", tmo_err, 0);

        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        seq(1'b0, 6,  1'b0, 30, 1'b1, 1'b0, "idle wake, busy pokes");
        seq(1'b1, 4,  1'b0, 12, 1'b1, 1'b0, "S1 busy pokes");

        repeat (5) @(negedge clk);
        chk(cur_vec() == V_IDLE, "R8 final idle", cur_vec(), V_IDLE);
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++; n_bad++;
            $display("FAIL %s: actual none expected %b", e.tag, e.v);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule